// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block is a small I/O-mapped register file for power-management events. It holds a 16-bit event status word and its enable word, a 16-bit control word, a free-running timer, a 32-bit system-management enable word, and a bank of general-purpose event status and enable bytes. Software reaches it through a simple port interface that carries an address, an access size, a write strobe, write data and registered read data.

Each register answers only at its own access width. When a 32-bit access finds no 32-bit register at its offset, it is carried out as two 16-bit sub-accesses to the same offset. When a 16-bit access finds no 16-bit register, it is carried out as two byte sub-accesses to the same offset. Sub-writes apply the low part first. Sub-reads return the first result in the upper part.

A level interrupt output is the OR, over four event sources, of status AND enable. A power-button request input, two further event inputs, a timer tick and general-purpose event inputs set the status bits. The whole window can be moved to a new base address or unmapped.

Top module: `pm_event_block`

## Requirements
- R1: `io_size` selects the access size: 0 is byte, 1 is 16-bit and 2 is 32-bit. The value 3 performs no access: it writes nothing and reads zero. `io_rdata` holds, one clock after an access is presented, the value read from the state before that edge.
- R2: The base register keeps `base_in` with its low 7 bits forced to zero, so the window is 128 bytes and always aligned. A base of zero unmaps the block. Accesses outside the window, or while unmapped, read zero and write nothing, and register state is kept across unmapping and relocation.
- R3: 16-bit accesses reach event status at offset 0x00, event enable at 0x02 and control at 0x04. Enable and control take the written value.
- R4: 32-bit accesses reach the timer at 0x08 (read only, zero-extended) and the system-management enable word at 0x30 (read/write).
- R5: Byte accesses reach only the general-purpose bank at 0x20 to 0x2F. Status bytes sit at 0x20 to 0x27 and enable bytes at 0x28 to 0x2F. A byte read elsewhere returns zero and a byte write elsewhere changes nothing.
- R6: An unclaimed 32-bit access becomes two 16-bit sub-accesses, and an unclaimed 16-bit access becomes two byte sub-accesses, all to the same offset. Writes apply the parts from low to high, so a plain register keeps the last part and a status register clears the OR of all parts. A read repeats the sub-result in every part, for example 0x05210521 for a 32-bit read of enable 0x0521.
- R7: Event status and general-purpose status bits are write-one-to-clear, and a zero written leaves a bit unchanged. Only event status bits 0, 5, 8 and 10 can ever read as one.
- R8: `sci` is high, one clock after the registers change, when status AND enable is non-zero on bit 0 (timer), 5 (global lock), 8 (power button) or 10 (clock alarm). General-purpose events never raise it.
- R9: `pwrbtn_req` sets status bit 8, `rtc_evt` sets bit 10 and `gbl_evt` sets bit 5. A set wins over a clear in the same cycle.
- R10: The timer increments once per clock in which `tick` is high and wraps to zero. Status bit 0 is set whenever the timer's top bit changes, in either direction.
- R11: `tmr_armed` is high, one clock after the registers change, exactly while timer enable bit 0 is set and timer status bit 0 is clear.
- R12: Reset clears the base (unmapping the block), all status and enable state, control, the timer, the system-management enable word, `io_rdata`, `sci` and `tmr_armed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Load the base register from `base_in` |
| base_in | input | ADDR_W | New base address (low 7 bits ignored) |
| io_addr | input | ADDR_W | Access address |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 none |
| io_wr | input | 1 | Write strobe for the presented access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Registered read data |
| tick | input | 1 | Timer advance enable |
| pwrbtn_req | input | 1 | Power-button request |
| rtc_evt | input | 1 | Clock-alarm event |
| gbl_evt | input | 1 | Global-lock release event |
| gpe_evt | input | 8*GPE_BYTES | General-purpose event set pulses |
| sci | output | 1 | Level event interrupt |
| tmr_armed | output | 1 | Timer overflow event armed |

## Verification
A status bit that is stuck, or cleared by a zero, shows on `sci` two clocks after the event or the write, and in the next 16-bit status read. A sub-access split that goes wrong (wrong part order, wrong replication, or a split to the wrong offset) changes a read value on the very next cycle. The table therefore reads back every register at every width after each write to it. A timer that miscounts, or misses the top-bit flip, shows as a wrong 32-bit timer value and a missing status bit after a known number of ticks, including at the wrap.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int BLK_AW = 7;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_NONE  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_WORD  = 2'd1,
    PATH_BYTE  = 2'd2,
    PATH_DWORD = 2'd3
  } path_e;

  localparam logic [BLK_AW-1:0] OFF_EVT_STS = 7'h00;
  localparam logic [BLK_AW-1:0] OFF_EVT_EN  = 7'h02;
  localparam logic [BLK_AW-1:0] OFF_CTL     = 7'h04;
  localparam logic [BLK_AW-1:0] OFF_TMR     = 7'h08;
  localparam logic [BLK_AW-1:0] OFF_GPE     = 7'h20;
  localparam logic [BLK_AW-1:0] OFF_SMIEN   = 7'h30;

  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  localparam logic [15:0] SRC_MASK = 16'h0521;
endpackage

// File: rtl/pmb_decode.sv
module pmb_decode
  import pmb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GPE_BYTES = 8,
  localparam int IDX_W    = (GPE_BYTES > 1) ? $clog2(GPE_BYTES) : 1
) (
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output path_e             path,
  output logic [BLK_AW-1:0] off,
  output logic              gpe_is_en,
  output logic [IDX_W-1:0]  gpe_idx,
  output logic [15:0]       or_word,
  output logic [15:0]       last_word,
  output logic [7:0]        or_byte,
  output logic [7:0]        last_byte
);
  localparam logic [BLK_AW-1:0] GPE_HALF = BLK_AW'(GPE_BYTES);
  localparam logic [BLK_AW-1:0] GPE_END  = OFF_GPE + BLK_AW'(2 * GPE_BYTES);

  logic mapped, in_win, is_dw_reg, is_w_reg, is_gpe;
  logic [BLK_AW-1:0] gpe_rel;

  assign mapped    = |base_q[ADDR_W-1:BLK_AW];
  assign in_win    = mapped && (addr[ADDR_W-1:BLK_AW] == base_q[ADDR_W-1:BLK_AW]);
  assign off       = addr[BLK_AW-1:0];
  assign is_dw_reg = (off == OFF_TMR) || (off == OFF_SMIEN);
  assign is_w_reg  = (off == OFF_EVT_STS) || (off == OFF_EVT_EN) || (off == OFF_CTL);
  assign is_gpe    = (off >= OFF_GPE) && (off < GPE_END);
  assign gpe_rel   = off - OFF_GPE;
  assign gpe_is_en = gpe_rel >= GPE_HALF;
  assign gpe_idx   = gpe_rel[IDX_W-1:0];

  always_comb begin
    path = PATH_NONE;
    if (in_win) begin
      unique case (size)
        SZ_DWORD: begin
          if (is_dw_reg)     path = PATH_DWORD;
          else if (is_w_reg) path = PATH_WORD;
          else if (is_gpe)   path = PATH_BYTE;
        end
        SZ_WORD: begin
          if (is_w_reg)      path = PATH_WORD;
          else if (is_gpe)   path = PATH_BYTE;
        end
        SZ_BYTE: begin
          if (is_gpe)        path = PATH_BYTE;
        end
        default: path = PATH_NONE;
      endcase
    end
  end

  // Sub-access merge: clears accumulate, plain writes keep the last part.
  always_comb begin
    unique case (size)
      SZ_DWORD: begin
        or_word   = wdata[15:0] | wdata[31:16];
        last_word = wdata[31:16];
        or_byte   = wdata[7:0] | wdata[15:8] | wdata[23:16] | wdata[31:24];
        last_byte = wdata[31:24];
      end
      SZ_WORD: begin
        or_word   = wdata[15:0];
        last_word = wdata[15:0];
        or_byte   = wdata[7:0] | wdata[15:8];
        last_byte = wdata[15:8];
      end
      default: begin
        or_word   = wdata[15:0];
        last_word = wdata[15:0];
        or_byte   = wdata[7:0];
        last_byte = wdata[7:0];
      end
    endcase
  end
endmodule

// File: rtl/pmb_evt.sv
module pmb_evt
  import pmb_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [15:0]      or_word,
  input  logic [15:0]      last_word,
  input  logic             tick,
  input  logic             pwr_set,
  input  logic             rtc_set,
  input  logic             gbl_set,
  output logic [15:0]      sts_q,
  output logic [15:0]      en_q,
  output logic [15:0]      ctl_q,
  output logic [TMR_W-1:0] tmr_q,
  output logic             sci_q,
  output logic             armed_q
);
  logic [TMR_W-1:0] tmr_d;
  logic             msb_flip;
  logic [15:0]      set_v, clr_v, sts_d;

  assign tmr_d    = tmr_q + TMR_W'(1);
  assign msb_flip = tick && (tmr_d[TMR_W-1] != tmr_q[TMR_W-1]);

  always_comb begin
    set_v          = '0;
    set_v[BIT_TMR] = msb_flip;
    set_v[BIT_GBL] = gbl_set;
    set_v[BIT_PWR] = pwr_set;
    set_v[BIT_RTC] = rtc_set;
    clr_v          = wr_sts ? or_word : 16'h0000;
    sts_d          = ((sts_q & ~clr_v) | set_v) & SRC_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= '0;
      en_q    <= '0;
      ctl_q   <= '0;
      tmr_q   <= '0;
      sci_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      if (wr_en)  en_q  <= last_word;
      if (wr_ctl) ctl_q <= last_word;
      if (tick)   tmr_q <= tmr_d;
      sci_q   <= |(sts_q & en_q & SRC_MASK);
      armed_q <= en_q[BIT_TMR] & ~sts_q[BIT_TMR];
    end
  end
endmodule

// File: rtl/pmb_gpe.sv
module pmb_gpe #(
  parameter int GPE_BYTES = 8,
  localparam int IDX_W    = (GPE_BYTES > 1) ? $clog2(GPE_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_sts,
  input  logic                   wr_en,
  input  logic                   rd_en_half,
  input  logic [IDX_W-1:0]       idx,
  input  logic [7:0]             or_byte,
  input  logic [7:0]             last_byte,
  input  logic [8*GPE_BYTES-1:0] evt,
  output logic [7:0]             rd_byte
);
  logic [7:0] sts_q [GPE_BYTES];
  logic [7:0] en_q  [GPE_BYTES];

  for (genvar g = 0; g < GPE_BYTES; g++) begin : g_byte
    logic sel;
    assign sel = (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q[g] <= '0;
        en_q[g]  <= '0;
      end else begin
        sts_q[g] <= (sts_q[g] & ~((wr_sts && sel) ? or_byte : 8'h00)) | evt[8*g +: 8];
        if (wr_en && sel) en_q[g] <= last_byte;
      end
    end
  end

  assign rd_byte = rd_en_half ? en_q[idx] : sts_q[idx];
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pmb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GPE_BYTES = 8,
  parameter int TMR_W     = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   base_wr,
  input  logic [ADDR_W-1:0]      base_in,
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [1:0]             io_size,
  input  logic                   io_wr,
  input  logic [31:0]            io_wdata,
  output logic [31:0]            io_rdata,
  input  logic                   tick,
  input  logic                   pwrbtn_req,
  input  logic                   rtc_evt,
  input  logic                   gbl_evt,
  input  logic [8*GPE_BYTES-1:0] gpe_evt,
  output logic                   sci,
  output logic                   tmr_armed
);
  localparam int IDX_W = (GPE_BYTES > 1) ? $clog2(GPE_BYTES) : 1;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BLK_AW) - 1);

  logic [ADDR_W-1:0] base_q;
  path_e             path;
  logic [BLK_AW-1:0] off;
  logic              gpe_is_en;
  logic [IDX_W-1:0]  gpe_idx;
  logic [15:0]       or_word, last_word;
  logic [7:0]        or_byte, last_byte, gpe_rd;
  logic [15:0]       pm1_sts, pm1_en, pm1_ctl, word_rd;
  logic [TMR_W-1:0]  tmr;
  logic [31:0]       smi_q, rd_d, rdata_q;
  logic              wr_sts, wr_en, wr_ctl, wr_smi, wr_gs, wr_ge;

  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (base_wr) base_q <= base_in & ALIGN_MASK;
  end

  pmb_decode #(.ADDR_W(ADDR_W), .GPE_BYTES(GPE_BYTES)) u_dec (
    .base_q(base_q), .addr(io_addr), .size(io_size), .wdata(io_wdata),
    .path(path), .off(off), .gpe_is_en(gpe_is_en), .gpe_idx(gpe_idx),
    .or_word(or_word), .last_word(last_word), .or_byte(or_byte), .last_byte(last_byte)
  );

  assign wr_sts = io_wr && (path == PATH_WORD)  && (off == OFF_EVT_STS);
  assign wr_en  = io_wr && (path == PATH_WORD)  && (off == OFF_EVT_EN);
  assign wr_ctl = io_wr && (path == PATH_WORD)  && (off == OFF_CTL);
  assign wr_smi = io_wr && (path == PATH_DWORD) && (off == OFF_SMIEN);
  assign wr_gs  = io_wr && (path == PATH_BYTE)  && !gpe_is_en;
  assign wr_ge  = io_wr && (path == PATH_BYTE)  && gpe_is_en;

  pmb_evt #(.TMR_W(TMR_W)) u_evt (
    .clk(clk), .rst(rst), .wr_sts(wr_sts), .wr_en(wr_en), .wr_ctl(wr_ctl),
    .or_word(or_word), .last_word(last_word), .tick(tick),
    .pwr_set(pwrbtn_req), .rtc_set(rtc_evt), .gbl_set(gbl_evt),
    .sts_q(pm1_sts), .en_q(pm1_en), .ctl_q(pm1_ctl), .tmr_q(tmr),
    .sci_q(sci), .armed_q(tmr_armed)
  );

  pmb_gpe #(.GPE_BYTES(GPE_BYTES)) u_gpe (
    .clk(clk), .rst(rst), .wr_sts(wr_gs), .wr_en(wr_ge), .rd_en_half(gpe_is_en),
    .idx(gpe_idx), .or_byte(or_byte), .last_byte(last_byte), .evt(gpe_evt),
    .rd_byte(gpe_rd)
  );

  always_ff @(posedge clk) begin
    if (rst)         smi_q <= '0;
    else if (wr_smi) smi_q <= io_wdata;
  end

  always_comb begin
    unique case (off)
      OFF_EVT_STS: word_rd = pm1_sts;
      OFF_EVT_EN:  word_rd = pm1_en;
      default:     word_rd = pm1_ctl;
    endcase
  end

  always_comb begin
    rd_d = '0;
    unique case (path)
      PATH_DWORD: begin
        if (off == OFF_TMR) rd_d[TMR_W-1:0] = tmr;
        else                rd_d = smi_q;
      end
      PATH_WORD: begin
        if (io_size == SZ_DWORD) rd_d = {word_rd, word_rd};
        else                     rd_d = {16'h0000, word_rd};
      end
      PATH_BYTE: begin
        if (io_size == SZ_DWORD)     rd_d = {4{gpe_rd}};
        else if (io_size == SZ_WORD) rd_d = {16'h0000, gpe_rd, gpe_rd};
        else                         rd_d = {24'h000000, gpe_rd};
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_d;
  end

  assign io_rdata = rdata_q;
endmodule

// File: rtl/pm_event_block_chk.sv
module pm_event_block_chk
  import pmb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int GPE_BYTES = 8,
  parameter int TMR_W     = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic [31:0]       io_rdata,
  input logic              pwrbtn_req,
  input logic              tick,
  input logic [15:0]       pm1_sts,
  input logic [15:0]       pm1_en,
  input logic [TMR_W-1:0]  tmr,
  input logic              sci
);
  localparam logic [BLK_AW-1:0] GPE_END = OFF_GPE + BLK_AW'(2 * GPE_BYTES);

  logic [BLK_AW-1:0] c_off;
  logic              c_in_gpe;
  assign c_off    = io_addr[BLK_AW-1:0];
  assign c_in_gpe = (c_off >= OFF_GPE) && (c_off < GPE_END);

  AST_UNMAPPED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (base_q == '0) |=> (io_rdata == 32'h0)); // R2

  AST_BYTE_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (io_size == 2'd0 && !c_in_gpe) |=> (io_rdata == 32'h0)); // R5

  AST_PWRBTN_LATCH: assert property (@(posedge clk) disable iff (rst)
    pwrbtn_req |=> pm1_sts[BIT_PWR]); // R9

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> (tmr == TMR_W'($past(tmr) + TMR_W'(1)))); // R10

  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tmr)); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pm1_sts == '0 && pm1_en == '0 && tmr == '0 && io_rdata == '0 && !sci)); // R12
endmodule

bind pm_event_block pm_event_block_chk #(
  .ADDR_W(ADDR_W), .GPE_BYTES(GPE_BYTES), .TMR_W(TMR_W)
) u_chk (
  .clk(clk), .rst(rst), .base_q(base_q), .io_addr(io_addr), .io_size(io_size),
  .io_rdata(io_rdata), .pwrbtn_req(pwrbtn_req), .tick(tick), .pm1_sts(pm1_sts),
  .pm1_en(pm1_en), .tmr(tmr), .sci(sci)
);

// File: tb/sim_pm_event_block.sv
module sim_pm_event_block;
  localparam int ADDR_W    = 16;
  localparam int GPE_BYTES = 8;
  localparam int TMR_W     = 8;
  localparam int NV        = 26;

  // {req[45:42], wr[41], size[40:39], off[38:32], data_or_expected[31:0]}
  localparam logic [45:0] VECS [NV] = '{
    {4'd3, 1'b1, 2'd1, 7'h02, 32'h0000_0521},  // R3 write enable
    {4'd3, 1'b0, 2'd1, 7'h02, 32'h0000_0521},  // R3
    {4'd6, 1'b0, 2'd2, 7'h02, 32'h0521_0521},  // R6 dword read split
    {4'd5, 1'b0, 2'd0, 7'h02, 32'h0000_0000},  // R5 byte outside bank
    {4'd6, 1'b1, 2'd2, 7'h02, 32'h0100_0020},  // R6 last word wins
    {4'd6, 1'b0, 2'd1, 7'h02, 32'h0000_0100},  // R6
    {4'd3, 1'b1, 2'd1, 7'h04, 32'h0000_1C01},  // R3 control
    {4'd3, 1'b0, 2'd1, 7'h04, 32'h0000_1C01},  // R3
    {4'd4, 1'b1, 2'd2, 7'h30, 32'hDEAD_BEEF},  // R4
    {4'd4, 1'b0, 2'd2, 7'h30, 32'hDEAD_BEEF},  // R4
    {4'd6, 1'b0, 2'd1, 7'h30, 32'h0000_0000},  // R6 word at dword reg -> bytes -> 0
    {4'd6, 1'b1, 2'd1, 7'h30, 32'h0000_0000},  // R6 ignored
    {4'd6, 1'b0, 2'd2, 7'h30, 32'hDEAD_BEEF},  // R6
    {4'd5, 1'b1, 2'd0, 7'h28, 32'h0000_005A},  // R5
    {4'd5, 1'b0, 2'd0, 7'h28, 32'h0000_005A},  // R5
    {4'd6, 1'b0, 2'd1, 7'h28, 32'h0000_5A5A},  // R6
    {4'd6, 1'b0, 2'd2, 7'h28, 32'h5A5A_5A5A},  // R6
    {4'd6, 1'b1, 2'd2, 7'h29, 32'h1122_3344},  // R6 last byte wins
    {4'd6, 1'b0, 2'd0, 7'h29, 32'h0000_0011},  // R6
    {4'd6, 1'b1, 2'd1, 7'h28, 32'h0000_7F80},  // R6
    {4'd6, 1'b0, 2'd0, 7'h28, 32'h0000_007F},  // R6
    {4'd4, 1'b0, 2'd2, 7'h08, 32'h0000_0000},  // R4 timer idle
    {4'd3, 1'b0, 2'd1, 7'h00, 32'h0000_0000},  // R3 status clear
    {4'd5, 1'b0, 2'd0, 7'h00, 32'h0000_0000},  // R5
    {4'd5, 1'b1, 2'd0, 7'h02, 32'h0000_00FF},  // R5 byte write ignored
    {4'd5, 1'b0, 2'd1, 7'h02, 32'h0000_0100}   // R5
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   base_wr = 1'b0;
  logic [ADDR_W-1:0]      base_in = '0;
  logic [ADDR_W-1:0]      io_addr = '0;
  logic [1:0]             io_size = 2'd3;
  logic                   io_wr = 1'b0;
  logic [31:0]            io_wdata = '0;
  logic [31:0]            io_rdata;
  logic                   tick = 1'b0;
  logic                   pwrbtn_req = 1'b0;
  logic                   rtc_evt = 1'b0;
  logic                   gbl_evt = 1'b0;
  logic [8*GPE_BYTES-1:0] gpe_evt = '0;
  logic                   sci, tmr_armed;

  int n_chk = 0;
  int n_fail = 0;
  logic [ADDR_W-1:0] cur_base = 16'h0400;
  logic [31:0] v;

  always #4 clk = ~clk;

  pm_event_block #(.ADDR_W(ADDR_W), .GPE_BYTES(GPE_BYTES), .TMR_W(TMR_W)) u0 (
    .clk(clk), .rst(rst), .base_wr(base_wr), .base_in(base_in), .io_addr(io_addr),
    .io_size(io_size), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .tick(tick), .pwrbtn_req(pwrbtn_req), .rtc_evt(rtc_evt), .gbl_evt(gbl_evt),
    .gpe_evt(gpe_evt), .sci(sci), .tmr_armed(tmr_armed)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_base(input logic [ADDR_W-1:0] b);
    @(negedge clk); base_wr = 1'b1; base_in = b;
    @(negedge clk); base_wr = 1'b0;
  endtask

  task automatic wr_abs(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); io_addr = a; io_size = sz; io_wr = 1'b1; io_wdata = d;
    @(negedge clk); io_wr = 1'b0; io_size = 2'd3;
  endtask

  task automatic rd_abs(input logic [ADDR_W-1:0] a, input logic [1:0] sz, output logic [31:0] r);
    @(negedge clk); io_addr = a; io_size = sz; io_wr = 1'b0;
    @(negedge clk); r = io_rdata; io_size = 2'd3;
  endtask

  task automatic wr_off(input logic [6:0] o, input logic [1:0] sz, input logic [31:0] d);
    wr_abs(cur_base + ADDR_W'(o), sz, d);
  endtask

  task automatic rd_off(input logic [6:0] o, input logic [1:0] sz, output logic [31:0] r);
    rd_abs(cur_base + ADDR_W'(o), sz, r);
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check("R12", "rdata after reset", io_rdata, 32'h0);
    check("R12", "sci after reset", {31'h0, sci}, 32'h0);
    check("R12", "armed after reset", {31'h0, tmr_armed}, 32'h0);
    // R2 unmapped: write ignored, read zero
    wr_abs(16'h0402, 2'd1, 32'h0000_0521);
    rd_abs(16'h0402, 2'd1, v);
    check("R2", "read while unmapped", v, 32'h0);
    set_base(16'h0455);  // R2 low bits dropped -> 0x0400
    rd_off(7'h02, 2'd1, v);
    check("R2", "write while unmapped had no effect", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][41]) begin
        wr_off(VECS[i][38:32], VECS[i][40:39], VECS[i][31:0]);
      end else begin
        rd_off(VECS[i][38:32], VECS[i][40:39], v);
        n_chk++;
        if (v !== VECS[i][31:0]) begin
          n_fail++;
          $display("FAIL R%0d table[%0d]: actual %h expected %h", VECS[i][45:42], i, v,
                   VECS[i][31:0]);
        end
      end
    end

    // R1 size 3 performs nothing
    wr_off(7'h02, 2'd3, 32'h0000_FFFF);
    rd_off(7'h02, 2'd1, v);
    check("R1", "size 3 write ignored", v, 32'h0000_0100);
    rd_off(7'h02, 2'd3, v);
    check("R1", "size 3 read zero", v, 32'h0);

    // R9 / R8 power button
    @(negedge clk); pwrbtn_req = 1'b1;
    @(negedge clk); pwrbtn_req = 1'b0;
    @(negedge clk);
    check("R8", "sci from power button", {31'h0, sci}, 32'h1);
    rd_off(7'h00, 2'd1, v);
    check("R9", "power status set", v, 32'h0000_0100);
    // R7 zero write keeps, one clears (via dword split high part, R6)
    wr_off(7'h00, 2'd1, 32'h0);
    rd_off(7'h00, 2'd1, v);
    check("R7", "zero write keeps status", v, 32'h0000_0100);
    wr_off(7'h00, 2'd2, 32'h0100_0000);
    rd_off(7'h00, 2'd1, v);
    check("R7", "dword high part clears status", v, 32'h0);
    @(negedge clk);
    check("R8", "sci drops after clear", {31'h0, sci}, 32'h0);
    // R9 set wins over clear
    @(negedge clk);
    io_addr = cur_base; io_size = 2'd1; io_wr = 1'b1; io_wdata = 32'h0100; pwrbtn_req = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_size = 2'd3; pwrbtn_req = 1'b0;
    rd_off(7'h00, 2'd1, v);
    check("R9", "set wins over clear", v, 32'h0000_0100);
    wr_off(7'h00, 2'd1, 32'h0100);

    // R8 general-purpose events never raise sci; R5/R7 bank status
    @(negedge clk); gpe_evt[7:0] = 8'hFF;
    @(negedge clk); gpe_evt = '0;
    settle();
    check("R8", "gpe event no sci", {31'h0, sci}, 32'h0);
    rd_off(7'h20, 2'd0, v);
    check("R5", "gpe status byte", v, 32'h0000_00FF);
    wr_off(7'h20, 2'd0, 32'h0000_000F);
    rd_off(7'h20, 2'd0, v);
    check("R7", "gpe w1c byte", v, 32'h0000_00F0);
    wr_off(7'h20, 2'd2, 32'h1020_4080);
    rd_off(7'h20, 2'd0, v);
    check("R6", "gpe dword clear accumulates", v, 32'h0);

    // R8 source masking: clock alarm not enabled, global lock enabled
    wr_off(7'h02, 2'd1, 32'h0000_0020);
    @(negedge clk); rtc_evt = 1'b1;
    @(negedge clk); rtc_evt = 1'b0;
    settle();
    check("R8", "rtc not enabled no sci", {31'h0, sci}, 32'h0);
    rd_off(7'h00, 2'd1, v);
    check("R9", "rtc status bit 10", v, 32'h0000_0400);
    @(negedge clk); gbl_evt = 1'b1;
    @(negedge clk); gbl_evt = 1'b0;
    @(negedge clk);
    check("R8", "global lock sci", {31'h0, sci}, 32'h1);
    wr_off(7'h00, 2'd1, 32'h0000_0420);
    @(negedge clk);
    check("R8", "sci cleared", {31'h0, sci}, 32'h0);

    // R10 / R11 timer
    wr_off(7'h02, 2'd1, 32'h0000_0001);
    @(negedge clk);
    check("R11", "armed with enable", {31'h0, tmr_armed}, 32'h1);
    @(negedge clk); tick = 1'b1;
    repeat (127) @(negedge clk);
    tick = 1'b0;
    rd_off(7'h08, 2'd2, v);
    check("R10", "timer after 127 ticks", v, 32'h0000_007F);
    rd_off(7'h00, 2'd1, v);
    check("R10", "no status before flip", v, 32'h0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd_off(7'h08, 2'd2, v);
    check("R10", "timer at 0x80", v, 32'h0000_0080);
    rd_off(7'h00, 2'd1, v);
    check("R10", "status on top bit rise", v, 32'h0000_0001);
    check("R8", "timer sci", {31'h0, sci}, 32'h1);
    check("R11", "disarmed on status", {31'h0, tmr_armed}, 32'h0);
    rd_off(7'h08, 2'd1, v);
    check("R4", "word read of timer is zero", v, 32'h0);
    wr_off(7'h00, 2'd1, 32'h0000_0001);
    @(negedge clk);
    check("R11", "rearmed after clear", {31'h0, tmr_armed}, 32'h1);
    @(negedge clk); tick = 1'b1;
    repeat (128) @(negedge clk);
    tick = 1'b0;
    rd_off(7'h08, 2'd2, v);
    check("R10", "timer wraps", v, 32'h0);
    rd_off(7'h00, 2'd1, v);
    check("R10", "status on top bit fall", v, 32'h0000_0001);

    // R12 reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_abs(16'h0408, 2'd2, v);
    check("R12", "reset unmaps", v, 32'h0);
    set_base(16'h0400);
    rd_off(7'h04, 2'd1, v);
    check("R12", "control cleared", v, 32'h0);
    rd_off(7'h30, 2'd2, v);
    check("R12", "smi enable cleared", v, 32'h0);
    rd_off(7'h28, 2'd0, v);
    check("R12", "gpe enable cleared", v, 32'h0);

    // R2 unmap keeps state, relocation
    wr_off(7'h02, 2'd1, 32'h0000_0001);
    set_base(16'h0000);
    rd_abs(16'h0002, 2'd1, v);
    check("R2", "base zero answers nothing", v, 32'h0);
    set_base(16'h0800);
    cur_base = 16'h0800;
    rd_off(7'h02, 2'd1, v);
    check("R2", "relocated keeps state", v, 32'h0000_0001);
    rd_abs(16'h0402, 2'd1, v);
    check("R2", "old window silent", v, 32'h0);

    summary();
  end
endmodule